// File: doc/BRIEF.md
# Edge-Triggered Interrupt and Wake Controller

This block is the interrupt front end for a small microcontroller core. It takes one external pin, which may change at any time, and passes it through a synchroniser. It then looks for the edge that a polarity control selects. A matching edge sets a sticky event flag. Software clears the flag by writing 0 through a strobe. A vector request goes to the core when the flag, the pin's local enable and the global interrupt enable are all set. Taking the vector clears the global enable, and an interrupt-return strobe sets it again.

The block also sequences sleep for the core. A sleep-request strobe stops the core clock. The core clock is modelled as an enable on the free-running clock, and the block keeps running on the free-running clock while the core is stopped. An enabled flag wakes the core whatever the global enable is. If the global enable is clear at wake-up, the core just carries on after the sleep instruction. If it is set, the vector request is held back until the core reports that one more instruction has finished.

Top module: `irq_wake_ctrl`

## Requirements
- R1: With `edge_pol` = 1 a 0-to-1 transition of `pin_in` is a valid event, and with `edge_pol` = 0 a 1-to-0 transition is a valid event; a valid event sets `pin_flag`.
- R2: A valid event sets `pin_flag` even when `pin_en` and `gie` are both 0, and a transition of the other direction leaves `pin_flag` at 0.
- R3: `pin_flag` stays 1 until a cycle with `flag_clr` = 1; if a valid event and `flag_clr` fall in the same cycle, the flag ends up 1.
- R4: `vec_req` is 1 only while `pin_flag`, `pin_en` and `gie` are all 1, the core is awake, and the block is not in the post-wake hold.
- R5: A `sleep_req` pulse while running makes `awake` and `core_clk_en` 0 from the next clock edge.
- R6: While asleep, the block wakes on the edge after `pin_flag` & `pin_en` is 1. A flag that is set while `pin_en` is 0 leaves the core asleep.
- R7: A wake with `gie` = 0 returns straight to running: `awake` is 1 and `vec_req` stays 0.
- R8: A wake with `gie` = 1 enters a hold in which `vec_req` is 0. The block leaves the hold on the edge where `instr_done` is 1, and `vec_req` then goes to 1.
- R9: `gie` is 0 after reset and is loaded from `gie_wr_val` when `gie_wr` is 1. A `vec_ack` clears it and a `reti` sets it, and `vec_ack` takes priority over both.
- R10: A change of `pin_in` sets `pin_flag` on the third rising clock edge after the change: there are two synchroniser stages and one edge-compare register.
- R11: After reset `pin_flag` = 0, `gie` = 0, `vec_req` = 0, `awake` = 1 and `core_clk_en` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Asynchronous interrupt pin |
| edge_pol | input | 1 | 1 selects rising edges, 0 falling |
| pin_en | input | 1 | Local enable of the pin source |
| gie_wr | input | 1 | Write strobe for the global enable |
| gie_wr_val | input | 1 | Value written to the global enable |
| flag_clr | input | 1 | Software write of 0 to the flag |
| vec_ack | input | 1 | Core takes the interrupt vector |
| reti | input | 1 | Return-from-interrupt strobe |
| sleep_req | input | 1 | Core executed its sleep instruction |
| instr_done | input | 1 | Core retired one instruction |
| pin_flag | output | 1 | Sticky pin event flag |
| gie | output | 1 | Global interrupt enable |
| vec_req | output | 1 | Vector request to the core |
| awake | output | 1 | 1 while the core runs |
| core_clk_en | output | 1 | Enable for the gated core clock |

## Verification
The hardest state to reach from the ports is the post-wake hold. It needs sleep entered with a clear flag, the global enable set, and then a valid pin edge that travels through the synchroniser while the core is stopped. The bench sets up these conditions in order and raises the edge through the pin. It checks `vec_req` at low level across several cycles before it pulses `instr_done`. The case where an edge and a clear arrive together is reached by counting the three-edge pin latency: `flag_clr` is driven exactly in the cycle before the flag would be set.

// File: rtl/irq_wake_pkg.sv
package irq_wake_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_HOLD  = 2'd2
  } wake_state_t;

  // Edge qualification: rising when pol is 1, falling when pol is 0.
  function automatic logic edge_match(input logic pol, input logic cur, input logic prev);
    return pol ? (cur & ~prev) : (~cur & prev);
  endfunction

endpackage

// File: rtl/pin_edge_det.sv
module pin_edge_det
  import irq_wake_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  input  logic edge_pol,
  output logic edge_evt
);

  logic [SYNC_DEPTH-1:0] sync_q;
  logic                  prev_q;
  logic                  sync_out;

  generate
    if (SYNC_DEPTH == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_DEPTH-2:0], pin_in};
      end
    end
  endgenerate

  assign sync_out = sync_q[SYNC_DEPTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_out;
  end

  assign edge_evt = edge_match(edge_pol, sync_out, prev_q);

  // R10: the compare register follows the synchroniser output by one cycle
  a_r10_prev_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (prev_q == $past(sync_out)));

endmodule

// File: rtl/wake_seq.sv
module wake_seq
  import irq_wake_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic wake_cond,
  input  logic gie,
  input  logic instr_done,
  output logic awake,
  output logic hold
);

  wake_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:   if (sleep_req) state_d = ST_SLEEP;
      ST_SLEEP: if (wake_cond) state_d = gie ? ST_HOLD : ST_RUN;
      ST_HOLD:  if (instr_done) state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  assign awake = (state_q != ST_SLEEP);
  assign hold  = (state_q == ST_HOLD);

  a_r5_sleep_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && !hold && sleep_req) |=> !awake);

  a_r6_stay_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    (!awake && !wake_cond) |=> !awake);

  a_r7_plain_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (!awake && wake_cond && !gie) |=> (awake && !hold));

  a_r8_hold_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !instr_done) |=> hold);

endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
  import irq_wake_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  input  logic edge_pol,
  input  logic pin_en,
  input  logic gie_wr,
  input  logic gie_wr_val,
  input  logic flag_clr,
  input  logic vec_ack,
  input  logic reti,
  input  logic sleep_req,
  input  logic instr_done,
  output logic pin_flag,
  output logic gie,
  output logic vec_req,
  output logic awake,
  output logic core_clk_en
);

  logic edge_evt;
  logic wake_cond;
  logic hold;

  pin_edge_det #(.SYNC_DEPTH(SYNC_DEPTH)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .edge_pol (edge_pol),
    .edge_evt (edge_evt)
  );

  // Sticky flag: a new event beats a software clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pin_flag <= 1'b0;
    else if (edge_evt) pin_flag <= 1'b1;
    else if (flag_clr) pin_flag <= 1'b0;
  end

  // Global enable: vector entry clears, return sets, software writes otherwise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gie <= 1'b0;
    else if (vec_ack) gie <= 1'b0;
    else if (reti)    gie <= 1'b1;
    else if (gie_wr)  gie <= gie_wr_val;
  end

  assign wake_cond = pin_flag & pin_en;

  wake_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_req  (sleep_req),
    .wake_cond  (wake_cond),
    .gie        (gie),
    .instr_done (instr_done),
    .awake      (awake),
    .hold       (hold)
  );

  assign vec_req     = wake_cond & gie & awake & ~hold;
  assign core_clk_en = awake;

  a_r1_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> pin_flag);

  a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_flag && !flag_clr) |=> pin_flag);

  a_r9_ack_clears_gie: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ack |=> !gie);

  a_r4_no_vec_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    !core_clk_en |-> !vec_req);

endmodule

// File: tb/tb_irq_wake_ctrl.sv
module tb_irq_wake_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_in = 1'b0, edge_pol = 1'b1, pin_en = 1'b0;
  logic gie_wr = 1'b0, gie_wr_val = 1'b0, flag_clr = 1'b0;
  logic vec_ack = 1'b0, reti = 1'b0, sleep_req = 1'b0, instr_done = 1'b0;
  logic pin_flag, gie, vec_req, awake, core_clk_en;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  irq_wake_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .edge_pol(edge_pol),
    .pin_en(pin_en), .gie_wr(gie_wr), .gie_wr_val(gie_wr_val),
    .flag_clr(flag_clr), .vec_ack(vec_ack), .reti(reti),
    .sleep_req(sleep_req), .instr_done(instr_done),
    .pin_flag(pin_flag), .gie(gie), .vec_req(vec_req),
    .awake(awake), .core_clk_en(core_clk_en)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Produce a valid edge of the requested direction, then wait out the latency
  task automatic fire(input logic rising);
    edge_pol = rising;
    pin_in = ~rising;
    repeat (3) step();
    pin_in = rising;
    repeat (3) step();
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; step(); flag_clr = 1'b0;
  endtask

  task automatic write_gie(input logic v);
    gie_wr = 1'b1; gie_wr_val = v; step(); gie_wr = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 flag", pin_flag, 1'b0);
    check("R11 gie", gie, 1'b0);
    check("R11 vec_req", vec_req, 1'b0);
    check("R11 awake", awake, 1'b1);
    check("R11 core_clk_en", core_clk_en, 1'b1);
  endtask

  task automatic t_latency();
    edge_pol = 1'b1;
    pin_in = 1'b1;
    step(); check("R10 flag after 1 edge", pin_flag, 1'b0);
    step(); check("R10 flag after 2 edges", pin_flag, 1'b0);
    step(); check("R10 R1 flag after 3 edges", pin_flag, 1'b1);
    clear_flag();
    check("R3 cleared by flag_clr", pin_flag, 1'b0);
  endtask

  task automatic t_polarity();
    fire(1'b0);
    check("R1 R2 falling edge sets flag with enables off", pin_flag, 1'b1);
    repeat (4) step();
    check("R3 flag sticky", pin_flag, 1'b1);
    clear_flag();
    edge_pol = 1'b0;
    pin_in = 1'b1;
    repeat (4) step();
    check("R2 rising edge ignored when falling chosen", pin_flag, 1'b0);
  endtask

  task automatic t_edge_wins();
    fire(1'b0);
    check("R3 flag set before race", pin_flag, 1'b1);
    edge_pol = 1'b1;
    pin_in = 1'b1;
    step(); step();
    flag_clr = 1'b1;
    step();
    flag_clr = 1'b0;
    check("R3 edge wins over clear", pin_flag, 1'b1);
    clear_flag();
    check("R3 clear alone", pin_flag, 1'b0);
  endtask

  task automatic t_vector();
    write_gie(1'b1);
    check("R9 gie written", gie, 1'b1);
    pin_en = 1'b0;
    fire(1'b1);
    check("R4 no vec without pin_en", vec_req, 1'b0);
    pin_en = 1'b1;
    step();
    check("R4 vec with all enables", vec_req, 1'b1);
    vec_ack = 1'b1; reti = 1'b1; step(); vec_ack = 1'b0; reti = 1'b0;
    check("R9 ack clears gie over reti", gie, 1'b0);
    check("R4 vec drops with gie", vec_req, 1'b0);
    reti = 1'b1; step(); reti = 1'b0;
    check("R9 reti sets gie", gie, 1'b1);
    check("R4 vec back", vec_req, 1'b1);
    write_gie(1'b0);
    check("R9 gie written 0", gie, 1'b0);
    clear_flag();
    pin_en = 1'b0;
  endtask

  task automatic t_sleep_plain();
    sleep_req = 1'b1; step(); sleep_req = 1'b0;
    check("R5 asleep", awake, 1'b0);
    check("R5 core clock stopped", core_clk_en, 1'b0);
    fire(1'b1);
    check("R6 flag set while asleep", pin_flag, 1'b1);
    step();
    check("R6 stays asleep without pin_en", awake, 1'b0);
    pin_en = 1'b1;
    step();
    check("R6 R7 woke", awake, 1'b1);
    check("R7 no vector with gie 0", vec_req, 1'b0);
    step();
    check("R7 still no vector", vec_req, 1'b0);
    clear_flag();
  endtask

  task automatic t_sleep_vector();
    write_gie(1'b1);
    sleep_req = 1'b1; step(); sleep_req = 1'b0;
    check("R5 asleep again", awake, 1'b0);
    fire(1'b1);
    check("R4 no vector while asleep", vec_req, 1'b0);
    step();
    check("R8 woke", awake, 1'b1);
    check("R8 vector held", vec_req, 1'b0);
    step(); step();
    check("R8 vector still held", vec_req, 1'b0);
    instr_done = 1'b1; step(); instr_done = 1'b0;
    check("R8 vector after one instruction", vec_req, 1'b1);
    vec_ack = 1'b1; step(); vec_ack = 1'b0;
    check("R9 gie cleared on vector", gie, 1'b0);
    clear_flag();
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_latency();
    t_polarity();
    t_edge_wins();
    t_vector();
    t_sleep_plain();
    t_sleep_vector();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule